// File: doc/BRIEF.md
# Performance Event to Counter Binding Table

This block records which programmable performance counter is tracking which hardware event. Software binds an event to a counter by writing a 20-bit event selector for that counter index. The selector carries a type in bits [19:16] and a code in bits [15:0]. For cache-type events (type 1), the code splits further into a cache identifier in bits [15:3], an operation in bits [2:1] and a result in bit [0].

Only five selectors are supported:

| Selector | Event |
| --- | --- |
| 0x00001 | cycles |
| 0x00002 | instructions |
| 0x10019 | data-translation read miss |
| 0x1001B | data-translation write miss |
| 0x10021 | instruction-translation miss |

Writing zero removes the counter's binding. Any other selector, and any write to a counter that may not be programmed, is refused and flagged.

At run time, an event strobe is looked up and the block returns the counter bound to that event. A separate query port reports whether a given counter is counting cycles or instructions. Each counter holds at most one binding, and each event is bound to at most one counter.

Top module: `pmu_evt_map`

## Requirements
- R1: Only selectors 0x00001, 0x00002, 0x10019, 0x1001B and 0x10021 (type in [19:16], code in [15:0]) may be bound. A write with any other non-zero selector raises `wr_err` and leaves the table unchanged.
- R2: A write is refused in any of these cases: the counter index is below 3, the index is at or above NUM_CTRS, the index's bit in `avail_mask` is clear, or the configuration is faulty. A refused write raises `wr_err` and leaves the table unchanged, even when the selector is zero.
- R3: A write of a supported selector that is not yet bound, to a valid counter, binds that event to the counter. It replaces any earlier binding of that counter.
- R4: A write of a supported selector already bound to any counter raises no error and changes nothing.
- R5: A write of zero to a valid counter removes that counter's binding without error.
- R6: A lookup with `lk_en` high returns its result on the next clock edge. If a binding exists, `lk_hit`=1 and `lk_ctr` is the bound index. Otherwise `lk_hit`=0 and `lk_ctr`=0. With `lk_en` low, `lk_hit` is 0.
- R7: One edge after `mon_ctr` is presented, the outputs report as follows:
  - Counter 0 reports `mon_cyc`=1 and `mon_ins`=0.
  - Counter 2 reports `mon_ins`=1 and `mon_cyc`=0.
  - Any other counter reports `mon_cyc` or `mon_ins` only when it is bound to cycles or to instructions respectively.
- R8: `cfg_bad` goes high one edge after `avail_mask` has any of bits 0 to 2 set, or has more than NUM_CTRS-3 bits set. While the mask is faulty, every write is refused.
- R9: After reset the table is empty and all outputs are 0.
- R10: `wr_err` is high for exactly the one cycle that follows each refused write.
- R11: A lookup or query in the same cycle as a write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| avail_mask | input | NUM_CTRS | Counters that software may program |
| cfg_bad | output | 1 | Registered configuration fault flag |
| wr_en | input | 1 | Binding write strobe |
| wr_ctr | input | IDX_W | Counter index of the write |
| wr_evt | input | 20 | Event selector written (zero clears) |
| wr_err | output | 1 | One-cycle pulse for a refused write |
| lk_en | input | 1 | Lookup strobe |
| lk_evt | input | 20 | Event selector looked up |
| lk_hit | output | 1 | Registered lookup hit |
| lk_ctr | output | IDX_W | Registered bound counter index |
| mon_ctr | input | IDX_W | Counter index being queried |
| mon_cyc | output | 1 | Queried counter tracks cycles |
| mon_ins | output | 1 | Queried counter tracks instructions |

## Verification
The checker watches every cycle for the following:
- `wr_err` and `lk_hit` appear only after a strobe.
- A hit never names a counter below 3.
- The two fixed counters always answer their fixed events.
- The cycle and instruction flags are never raised together.

Only the bench's scenarios can show the parts that depend on history. These include binding, replacement, the silently ignored duplicate, the clearing write, and refusal leaving the table intact. They also include the pre-write view seen by a lookup issued alongside a write. The bench checks these against a reference table kept in its own functions.

// File: rtl/pmu_evt_map_pkg.sv
package pmu_evt_map_pkg;
  localparam int EVT_W = 20;

  typedef enum logic [2:0] {
    EVC_NONE    = 3'd0,
    EVC_CYCLES  = 3'd1,
    EVC_INSTR   = 3'd2,
    EVC_DTR_RD  = 3'd3,
    EVC_DTR_WR  = 3'd4,
    EVC_ITR_MS  = 3'd5
  } evt_class_e;
endpackage

// File: rtl/pmu_evt_decode.sv
module pmu_evt_decode
  import pmu_evt_map_pkg::*;
(
  input  logic [EVT_W-1:0] evt_i,
  output evt_class_e       cls_o,
  output logic             sup_o
);
  logic [3:0]  ev_type;
  logic [15:0] ev_code;
  logic [12:0] cache_id;
  logic [1:0]  cache_op;
  logic        cache_res;

  assign ev_type   = evt_i[19:16];
  assign ev_code   = evt_i[15:0];
  assign cache_id  = ev_code[15:3];
  assign cache_op  = ev_code[2:1];
  assign cache_res = ev_code[0];

  always_comb begin
    cls_o = EVC_NONE;
    if (ev_type == 4'd0) begin
      if (ev_code == 16'd1)      cls_o = EVC_CYCLES;
      else if (ev_code == 16'd2) cls_o = EVC_INSTR;
    end else if (ev_type == 4'd1 && cache_res) begin
      if (cache_id == 13'd3 && cache_op == 2'd0)      cls_o = EVC_DTR_RD;
      else if (cache_id == 13'd3 && cache_op == 2'd1) cls_o = EVC_DTR_WR;
      else if (cache_id == 13'd4 && cache_op == 2'd0) cls_o = EVC_ITR_MS;
    end
  end

  assign sup_o = (cls_o != EVC_NONE);
endmodule

// File: rtl/pmu_evt_table.sv
module pmu_evt_table
  import pmu_evt_map_pkg::*;
#(
  parameter int NUM_CTRS = 32,
  localparam int CW = $clog2(NUM_CTRS)
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                set_i,
  input  logic                clr_i,
  input  logic [CW-1:0]       wr_idx_i,
  input  evt_class_e          wr_cls_i,
  input  evt_class_e          key_a_i,
  output logic [NUM_CTRS-1:0] match_a_o,
  input  evt_class_e          key_b_i,
  output logic                any_b_o,
  input  logic [CW-1:0]       rd_idx_i,
  output logic                rd_vld_o,
  output evt_class_e          rd_cls_o
);
  logic       vld_q [NUM_CTRS];
  evt_class_e cls_q [NUM_CTRS];
  logic [NUM_CTRS-1:0] match_b;

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[i] <= 1'b0;
        cls_q[i] <= EVC_NONE;
      end else if (wr_idx_i == CW'(i)) begin
        if (clr_i) begin
          vld_q[i] <= 1'b0;
        end else if (set_i) begin
          vld_q[i] <= 1'b1;
          cls_q[i] <= wr_cls_i;
        end
      end
    end
    assign match_a_o[i] = vld_q[i] && (cls_q[i] == key_a_i);
    assign match_b[i]   = vld_q[i] && (cls_q[i] == key_b_i);
  end

  assign any_b_o  = |match_b;
  assign rd_vld_o = vld_q[rd_idx_i];
  assign rd_cls_o = cls_q[rd_idx_i];
endmodule

// File: rtl/pmu_idx_encode.sv
module pmu_idx_encode #(
  parameter int N     = 32,
  parameter int OUT_W = 6
)(
  input  logic [N-1:0]     vec_i,
  output logic [OUT_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) idx_o = OUT_W'(i);
    end
  end
endmodule

// File: rtl/pmu_evt_map.sv
module pmu_evt_map
  import pmu_evt_map_pkg::*;
#(
  parameter int NUM_CTRS = 32,
  parameter int IDX_W    = $clog2(NUM_CTRS) + 1
)(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CTRS-1:0] avail_mask,
  output logic                cfg_bad,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_ctr,
  input  logic [EVT_W-1:0]    wr_evt,
  output logic                wr_err,
  input  logic                lk_en,
  input  logic [EVT_W-1:0]    lk_evt,
  output logic                lk_hit,
  output logic [IDX_W-1:0]    lk_ctr,
  input  logic [IDX_W-1:0]    mon_ctr,
  output logic                mon_cyc,
  output logic                mon_ins
);
  localparam int CW        = $clog2(NUM_CTRS);
  localparam int FIRST_PRG = 3;
  localparam int MAX_PRG   = NUM_CTRS - FIRST_PRG;

  evt_class_e wr_cls, lk_cls, rd_cls;
  logic wr_sup, lk_sup, rd_vld, dup_b;
  logic cfg_fault, ctr_ok, wr_zero, do_set, do_clr, refuse;
  logic [NUM_CTRS-1:0] hit_vec;
  logic [IDX_W-1:0] hit_idx;
  logic mon_in_rng;

  pmu_evt_decode u_dec_wr (.evt_i(wr_evt), .cls_o(wr_cls), .sup_o(wr_sup));
  pmu_evt_decode u_dec_lk (.evt_i(lk_evt), .cls_o(lk_cls), .sup_o(lk_sup));

  assign cfg_fault = (|avail_mask[FIRST_PRG-1:0]) ||
                     ($countones(avail_mask) > MAX_PRG);
  assign ctr_ok    = !cfg_fault && (wr_ctr >= IDX_W'(FIRST_PRG)) &&
                     (wr_ctr < IDX_W'(NUM_CTRS)) && avail_mask[wr_ctr[CW-1:0]];
  assign wr_zero   = (wr_evt == '0);
  assign refuse    = wr_en && !(ctr_ok && (wr_zero || wr_sup));
  assign do_clr    = wr_en && ctr_ok && wr_zero;
  assign do_set    = wr_en && ctr_ok && wr_sup && !dup_b;

  pmu_evt_table #(.NUM_CTRS(NUM_CTRS)) u_tab (
    .clk(clk), .rst(rst),
    .set_i(do_set), .clr_i(do_clr),
    .wr_idx_i(wr_ctr[CW-1:0]), .wr_cls_i(wr_cls),
    .key_a_i(lk_cls), .match_a_o(hit_vec),
    .key_b_i(wr_cls), .any_b_o(dup_b),
    .rd_idx_i(mon_ctr[CW-1:0]), .rd_vld_o(rd_vld), .rd_cls_o(rd_cls)
  );

  pmu_idx_encode #(.N(NUM_CTRS), .OUT_W(IDX_W)) u_enc (
    .vec_i(hit_vec), .idx_o(hit_idx)
  );

  assign mon_in_rng = (mon_ctr < IDX_W'(NUM_CTRS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_bad <= 1'b0;
      wr_err  <= 1'b0;
      lk_hit  <= 1'b0;
      lk_ctr  <= '0;
      mon_cyc <= 1'b0;
      mon_ins <= 1'b0;
    end else begin
      cfg_bad <= cfg_fault;
      wr_err  <= refuse;
      lk_hit  <= lk_en && lk_sup && (|hit_vec);
      lk_ctr  <= (lk_en && lk_sup && (|hit_vec)) ? hit_idx : '0;
      mon_cyc <= (mon_ctr == '0) ||
                 (mon_in_rng && mon_ctr != IDX_W'(2) && rd_vld && rd_cls == EVC_CYCLES);
      mon_ins <= (mon_ctr == IDX_W'(2)) ||
                 (mon_in_rng && mon_ctr != '0 && rd_vld && rd_cls == EVC_INSTR);
    end
  end
endmodule

// File: rtl/pmu_evt_map_chk.sv
module pmu_evt_map_chk #(
  parameter int IDX_W = 6
)(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_err,
  input logic             lk_en,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_ctr,
  input logic [IDX_W-1:0] mon_ctr,
  input logic             mon_cyc,
  input logic             mon_ins
);
  // R10
  err_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_en));
  // R6
  hit_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_en));
  // R2
  hit_ctr_legal_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_ctr >= IDX_W'(3)));
  // R7
  ctr0_cycles_chk: assert property (@(posedge clk) disable iff (rst)
    (mon_ctr == '0) |=> (mon_cyc && !mon_ins));
  // R7
  ctr2_instr_chk: assert property (@(posedge clk) disable iff (rst)
    (mon_ctr == IDX_W'(2)) |=> (mon_ins && !mon_cyc));
  // R7
  mon_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mon_cyc, mon_ins}));
endmodule

bind pmu_evt_map pmu_evt_map_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_err(wr_err),
  .lk_en(lk_en), .lk_hit(lk_hit), .lk_ctr(lk_ctr),
  .mon_ctr(mon_ctr), .mon_cyc(mon_cyc), .mon_ins(mon_ins)
);

// File: tb/pmu_evt_map_tb_top.sv
module pmu_evt_map_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTRS   = 32;
  localparam int IDX_W      = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_CTRS-1:0] avail_mask;
  logic cfg_bad, wr_en, wr_err, lk_en, lk_hit, mon_cyc, mon_ins;
  logic [IDX_W-1:0] wr_ctr, lk_ctr, mon_ctr;
  logic [19:0] wr_evt, lk_evt;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  bit ref_v [NUM_CTRS];
  int ref_c [NUM_CTRS];

  logic [19:0] wl [5] = '{20'h00001, 20'h00002, 20'h10019, 20'h1001B, 20'h10021};

  pmu_evt_map #(.NUM_CTRS(NUM_CTRS), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .avail_mask(avail_mask), .cfg_bad(cfg_bad),
    .wr_en(wr_en), .wr_ctr(wr_ctr), .wr_evt(wr_evt), .wr_err(wr_err),
    .lk_en(lk_en), .lk_evt(lk_evt), .lk_hit(lk_hit), .lk_ctr(lk_ctr),
    .mon_ctr(mon_ctr), .mon_cyc(mon_cyc), .mon_ins(mon_ins)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int cls_of(logic [19:0] e);
    for (int k = 0; k < 5; k++) if (e == wl[k]) return k + 1;
    return 0;
  endfunction

  function automatic bit mask_fault(logic [NUM_CTRS-1:0] m);
    return (m[2:0] != 0) || ($countones(m) > NUM_CTRS - 3);
  endfunction

  function automatic bit idx_ok(int c);
    return !mask_fault(avail_mask) && c >= 3 && c < NUM_CTRS && avail_mask[c];
  endfunction

  function automatic int bound_ctr(int cls);
    for (int c = 0; c < NUM_CTRS; c++) if (ref_v[c] && ref_c[c] == cls) return c;
    return -1;
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit we, int wc, logic [19:0] wv, bit le, logic [19:0] lv,
                      int mc, string req);
    bit e_err, e_hit, e_cyc, e_ins;
    int e_ctr, wcls, lcls, b;
    @(negedge clk);
    wr_en = we; wr_ctr = IDX_W'(wc); wr_evt = wv;
    lk_en = le; lk_evt = lv; mon_ctr = IDX_W'(mc);
    wcls = cls_of(wv);
    lcls = cls_of(lv);
    e_err = we && !(idx_ok(wc) && (wv == 0 || wcls != 0));
    b = (lcls != 0) ? bound_ctr(lcls) : -1;
    e_hit = le && b >= 0;
    e_ctr = e_hit ? b : 0;
    e_cyc = (mc == 0) || (mc != 2 && mc < NUM_CTRS && ref_v[mc] && ref_c[mc] == 1);
    e_ins = (mc == 2) || (mc != 0 && mc < NUM_CTRS && ref_v[mc] && ref_c[mc] == 2);
    @(posedge clk);
    #1;
    cmp(req, "wr_err", int'(wr_err), int'(e_err));
    cmp(req, "lk_hit", int'(lk_hit), int'(e_hit));
    cmp(req, "lk_ctr", int'(lk_ctr), e_ctr);
    cmp(req, "mon_cyc", int'(mon_cyc), int'(e_cyc));
    cmp(req, "mon_ins", int'(mon_ins), int'(e_ins));
    if (we && idx_ok(wc)) begin
      if (wv == 0) ref_v[wc] = 0;
      else if (wcls != 0 && bound_ctr(wcls) < 0) begin
        ref_v[wc] = 1; ref_c[wc] = wcls;
      end
    end
    wr_en = 0; lk_en = 0;
  endtask

  function automatic logic [19:0] rand_evt();
    int r = $urandom_range(0, 99);
    if (r < 60) return wl[$urandom_range(0, 4)];
    if (r < 75) return 20'h0;
    if (r < 88) return wl[$urandom_range(0, 4)] ^ 20'(1 << $urandom_range(0, 19));
    return 20'($urandom);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    avail_mask = 32'hFFFF_FFF8 & ~(32'h1 << 7);
    wr_en = 0; wr_ctr = 0; wr_evt = 0; lk_en = 0; lk_evt = 0; mon_ctr = 1;
    for (int c = 0; c < NUM_CTRS; c++) begin ref_v[c] = 0; ref_c[c] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    cmp("R9", "wr_err", int'(wr_err), 0);
    cmp("R9", "lk_hit", int'(lk_hit), 0);
    cmp("R9", "mon_cyc", int'(mon_cyc), 0);
    cmp("R9", "cfg_bad", int'(cfg_bad), 0);
    @(negedge clk); rst = 0;
    for (int k = 0; k < 5; k++) step(0, 0, 0, 1, wl[k], 5, "R9");

    // R3 bind, R6 lookup, R7 query
    step(1, 5, 20'h00001, 0, 0, 1, "R3");
    step(0, 0, 0, 1, 20'h00001, 5, "R6");
    step(0, 0, 0, 0, 20'h00001, 0, "R7");
    step(0, 0, 0, 0, 0, 2, "R7");
    // R4 duplicate
    step(1, 6, 20'h00001, 1, 20'h00001, 6, "R4");
    step(0, 0, 0, 1, 20'h00001, 6, "R4");
    // R3 replacement
    step(1, 5, 20'h00002, 0, 0, 5, "R3");
    step(0, 0, 0, 1, 20'h00001, 5, "R3");
    step(0, 0, 0, 1, 20'h00002, 5, "R7");
    // R5 clear
    step(1, 5, 20'h0, 0, 0, 5, "R5");
    step(0, 0, 0, 1, 20'h00002, 5, "R5");
    // R2 refused indices, R10 pulse
    step(1, 2, 20'h00001, 0, 0, 2, "R2");
    step(0, 0, 0, 0, 0, 1, "R10");
    step(1, 7, 20'h00002, 1, 20'h00002, 7, "R2");
    step(1, 40, 20'h10021, 1, 20'h10021, 1, "R2");
    step(1, 1, 20'h0, 0, 0, 1, "R2");
    // R1 unsupported selectors
    step(1, 9, 20'h10018, 1, 20'h10019, 9, "R1");
    step(1, 9, 20'h00003, 1, 20'h00003, 9, "R1");
    step(1, 9, 20'h20019, 0, 0, 9, "R1");
    // R11 same-cycle write and lookup
    step(1, 9, 20'h10019, 1, 20'h10019, 9, "R11");
    step(0, 0, 0, 1, 20'h10019, 9, "R11");
    step(1, 12, 20'h1001B, 1, 20'h1001B, 12, "R3");
    step(0, 0, 0, 1, 20'h1001B, 12, "R6");

    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), $urandom_range(0, 35), rand_evt(),
           $urandom_range(0, 3) != 0, rand_evt(), $urandom_range(0, 35), "R6");

    // R8 configuration fault
    @(negedge clk);
    avail_mask = avail_mask | 32'h1;
    @(posedge clk); #1;
    cmp("R8", "cfg_bad", int'(cfg_bad), 1);
    step(1, 20, 20'h00002, 0, 0, 1, "R8");
    step(1, 21, 20'h0, 0, 0, 1, "R8");
    @(negedge clk);
    avail_mask = avail_mask & ~32'h1;
    @(posedge clk); #1;
    cmp("R8", "cfg_bad", int'(cfg_bad), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule